// File: doc/BRIEF.md
# DDR Read Capture Resynchronizer

This block receives read bursts returning from a DDR SDRAM and hands them to the system bus clock domain. The returned word is split into nine byte lanes: eight carry the 64 data bits and one carries the 8 check bits. Each lane has its own strobe. The strobe reaches the block already delayed by a quarter of a memory clock period, which is 1.875 ns at 133 MHz. Each lane passes its byte through three registers in a row. The first is a transparent latch plus flop that captures on the lane strobe. The second and third are flops clocked by a separately phased read clock.

A two-bit stage select picks which of the three stages feeds a single sampling register on the bus clock. Software sets this select to the earliest stage that the board's timing allows, which gives minimum read latency without sampling a changing value. A small control state machine runs on the bus clock. It captures the select and the CAS-latency offset when a read command arrives. It then counts out the latency and raises the valid flag for exactly one burst.

The state machine has three states. IDLE waits for a read command. On a command it takes the transition IDLE to WAIT, loading the latency counter and the stage choice. WAIT counts down, and when the counter reaches one it takes WAIT to XFER, loading the beat counter. XFER presents one beat per bus cycle. After the final beat it takes XFER to IDLE. Any state code outside these three returns to IDLE.

Top module: `rdcap_resync`

## Requirements
- R1: While reset is asserted and right after it, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: Stage select code 0 selects stage 1, code 1 selects stage 2 and code 2 selects stage 3. The first valid beat appears `cas_ofs + code` bus cycles after the bus edge that accepted the read command.
- R3: Stage select code 3 behaves exactly like code 2, in both latency and data.
- R4: Each valid beat equals the word captured on the lane strobes, in capture order. Lane k appears at bits [8k+7:8k], and the check-bit lane (lane 8) appears at bits [71:64].
- R5: Each accepted command produces exactly BURST_LEN (default 4) consecutive valid cycles. `rd_valid` is 0 at all other times.
- R6: The stage select and `cas_ofs` are sampled only when a command is accepted. Changing them while a burst is in flight does not alter that burst's latency or data.
- R7: A read command that arrives while a burst is in WAIT or XFER is ignored. It produces no extra valid cycles.
- R8: A `cas_ofs` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | System bus clock; drives the control FSM and the sampling register |
| rst_n | input | 1 | Asynchronous active-low reset for the bus clock domain |
| rd_clk | input | 1 | Programmed read clock for stages 2 and 3 |
| strobe_dly | input | 9 | Quarter-cycle-delayed data strobe, one per lane |
| lane_data | input | 72 | Byte-lane read data from the pads; lane k at [8k+7:8k] |
| rd_cmd | input | 1 | Read command pulse, sampled on bus_clk |
| stage_sel | input | 2 | Stage select code: 0, 1 or 2 for stages 1 to 3; 3 acts as 2 |
| cas_ofs | input | 3 | Latency offset in bus cycles; 0 acts as 1 |
| rd_data | output | 72 | Sampled read word |
| rd_valid | output | 1 | High for each bus cycle that carries a burst beat |

## Verification
The hardest case is the boundary between stages. Each of the three stage outputs holds a different beat during any given bus cycle, so a wrong select or a latency off by one cycle shows up as a neighbouring beat, not as garbage. The bench models the strobe and the read clock as clocks phase-shifted from the bus clock, so that each stage adds exactly one bus cycle. It drives a new random word into every strobe period, both during and between bursts. Random bursts cover every select code and offset. Some of them change the select and offset in mid-flight and re-issue the command while a burst is running.

// File: rtl/rdcap_pkg.sv
package rdcap_pkg;

    // Pipeline stage that feeds the bus-clock sampling register
    typedef enum logic [1:0] {
        STG_CAPTURE = 2'd0,
        STG_RETIME  = 2'd1,
        STG_SETTLE  = 2'd2
    } stage_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } ctl_state_e;

    // R3: the reserved code folds onto the last stage
    function automatic stage_e decode_stage(input logic [1:0] code);
        stage_e s;
        unique case (code)
            2'd0:    s = STG_CAPTURE;
            2'd1:    s = STG_RETIME;
            default: s = STG_SETTLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rdcap_lane.sv
module rdcap_lane #(
    parameter int LANE_W = 8
) (
    input  logic              strobe,
    input  logic              rd_clk,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] stg1_o,
    output logic [LANE_W-1:0] stg2_o,
    output logic [LANE_W-1:0] stg3_o
);

    logic [LANE_W-1:0] open_q;

    // Stage 1: latch open while the strobe is low, flop on its rising edge
    always_latch begin
        if (!strobe) begin
            open_q <= din;
        end
    end

    always_ff @(posedge strobe) begin
        stg1_o <= open_q;
    end

    // Stages 2 and 3 on the programmed read clock
    always_ff @(posedge rd_clk) begin
        stg2_o <= stg1_o;
        stg3_o <= stg2_o;
    end

endmodule

// File: rtl/rdcap_ctrl.sv
module rdcap_ctrl
    import rdcap_pkg::*;
#(
    parameter int CAS_W     = 3,
    parameter int BURST_LEN = 4
) (
    input  logic             bus_clk,
    input  logic             rst_n,
    input  logic             rd_cmd,
    input  logic [1:0]       stage_sel,
    input  logic [CAS_W-1:0] cas_ofs,
    output stage_e           sel_q,
    output ctl_state_e       state_q,
    output logic             valid_q
);

    localparam int LAT_W  = CAS_W + 1;
    localparam int BEAT_W = $clog2(BURST_LEN + 1);

    ctl_state_e        st_n;
    stage_e            sel_n, sel_dec;
    logic [LAT_W-1:0]  wait_q, wait_n, lat_req, cas_eff;
    logic [BEAT_W-1:0] beat_q, beat_n;

    always_comb begin
        sel_dec = decode_stage(stage_sel);
        // R8: zero offset counts as one
        cas_eff = (cas_ofs == '0) ? LAT_W'(1) : LAT_W'(cas_ofs);
        lat_req = cas_eff + {{(LAT_W-2){1'b0}}, sel_dec};
    end

    always_comb begin
        st_n   = state_q;
        wait_n = wait_q;
        beat_n = beat_q;
        sel_n  = sel_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_cmd) begin
                    st_n   = ST_WAIT;
                    wait_n = lat_req;
                    sel_n  = sel_dec;
                end
            end
            ST_WAIT: begin
                if (wait_q == LAT_W'(1)) begin
                    st_n   = ST_XFER;
                    beat_n = BEAT_W'(BURST_LEN - 1);
                end else begin
                    wait_n = wait_q - LAT_W'(1);
                end
            end
            ST_XFER: begin
                if (beat_q == '0) begin
                    st_n = ST_IDLE;
                end else begin
                    beat_n = beat_q - BEAT_W'(1);
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wait_q  <= '0;
            beat_q  <= '0;
            sel_q   <= STG_CAPTURE;
        end else begin
            state_q <= st_n;
            wait_q  <= wait_n;
            beat_q  <= beat_n;
            sel_q   <= sel_n;
        end
    end

    // Output register
    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= (st_n == ST_XFER);
        end
    end

endmodule

// File: rtl/rdcap_resync.sv
module rdcap_resync
    import rdcap_pkg::*;
#(
    parameter int LANES     = 9,
    parameter int LANE_W    = 8,
    parameter int CAS_W     = 3,
    parameter int BURST_LEN = 4
) (
    input  logic                      bus_clk,
    input  logic                      rst_n,
    input  logic                      rd_clk,
    input  logic [LANES-1:0]          strobe_dly,
    input  logic [LANES*LANE_W-1:0]   lane_data,
    input  logic                      rd_cmd,
    input  logic [1:0]                stage_sel,
    input  logic [CAS_W-1:0]          cas_ofs,
    output logic [LANES*LANE_W-1:0]   rd_data,
    output logic                      rd_valid
);

    localparam int DW = LANES * LANE_W;

    logic [DW-1:0] stg1, stg2, stg3, pick;
    stage_e        sel_q;
    ctl_state_e    ctl_st;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        rdcap_lane #(.LANE_W(LANE_W)) lane_i (
            .strobe (strobe_dly[k]),
            .rd_clk (rd_clk),
            .din    (lane_data[k*LANE_W +: LANE_W]),
            .stg1_o (stg1[k*LANE_W +: LANE_W]),
            .stg2_o (stg2[k*LANE_W +: LANE_W]),
            .stg3_o (stg3[k*LANE_W +: LANE_W])
        );
    end

    rdcap_ctrl #(.CAS_W(CAS_W), .BURST_LEN(BURST_LEN)) ctrl_i (
        .bus_clk   (bus_clk),
        .rst_n     (rst_n),
        .rd_cmd    (rd_cmd),
        .stage_sel (stage_sel),
        .cas_ofs   (cas_ofs),
        .sel_q     (sel_q),
        .state_q   (ctl_st),
        .valid_q   (rd_valid)
    );

    // Read-select multiplexer
    always_comb begin
        unique case (sel_q)
            STG_CAPTURE: pick = stg1;
            STG_RETIME:  pick = stg2;
            default:     pick = stg3;
        endcase
    end

    // Bus-clock sampling register
    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= pick;
        end
    end

endmodule

// File: rtl/rdcap_chk.sv
module rdcap_chk
    import rdcap_pkg::*;
#(
    parameter int CAS_W     = 3,
    parameter int BURST_LEN = 4
) (
    input logic             bus_clk,
    input logic             rst_n,
    input logic             rd_cmd,
    input logic [1:0]       stage_sel,
    input logic [CAS_W-1:0] cas_ofs,
    input logic             rd_valid,
    input ctl_state_e       ctl_st,
    input stage_e           sel_q
);

    localparam int LAT_W = CAS_W + 1;
    localparam int RUN_W = $clog2(BURST_LEN + 1) + 1;

    logic             busy;
    logic [LAT_W-1:0] cnt, lat_f;
    logic [RUN_W-1:0] run;

    always_comb begin
        lat_f = ((cas_ofs == '0) ? LAT_W'(1) : LAT_W'(cas_ofs))
              + ((stage_sel == 2'd3) ? LAT_W'(2) : LAT_W'(stage_sel));
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            run  <= '0;
        end else begin
            run <= rd_valid ? run + RUN_W'(1) : '0;
            if (!busy) begin
                if (rd_cmd) begin
                    busy <= 1'b1;
                    cnt  <= lat_f;
                end
            end else if (cnt != '0) begin
                cnt <= cnt - LAT_W'(1);
            end else if (rd_valid && run == RUN_W'(BURST_LEN - 1)) begin
                busy <= 1'b0;
            end
        end
    end

    // R2
    lat_rise_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (busy && cnt == LAT_W'(1)) |=> $rose(rd_valid));

    // R2
    rise_src_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        $rose(rd_valid) |-> ($past(busy) && $past(cnt) == LAT_W'(1)));

    // R5
    run_max_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        rd_valid |-> (run < RUN_W'(BURST_LEN)));

    // R5
    run_len_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        $fell(rd_valid) |-> ($past(run) == RUN_W'(BURST_LEN - 1)));

    // R6
    sel_hold_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (ctl_st != ST_IDLE && $past(ctl_st) != ST_IDLE) |-> $stable(sel_q));

    // R7
    cmd_ign_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (ctl_st == ST_XFER && rd_cmd) |=> (ctl_st != ST_WAIT));

endmodule

bind rdcap_resync rdcap_chk #(.CAS_W(CAS_W), .BURST_LEN(BURST_LEN)) chk_i (
    .bus_clk   (bus_clk),
    .rst_n     (rst_n),
    .rd_cmd    (rd_cmd),
    .stage_sel (stage_sel),
    .cas_ofs   (cas_ofs),
    .rd_valid  (rd_valid),
    .ctl_st    (ctl_st),
    .sel_q     (sel_q)
);

// File: tb/rdcap_resync_tb.sv
module rdcap_resync_tb_top;

    localparam int LANES = 9;
    localparam int LANE_W = 8;
    localparam int DW = LANES * LANE_W;
    localparam int CAS_W = 3;
    localparam int BL = 4;

    logic             bus_clk, rd_clk, strobe, rst_n, rd_cmd, rd_valid;
    logic [1:0]       stage_sel;
    logic [CAS_W-1:0] cas_ofs;
    logic [DW-1:0]    lane_data, rd_data;
    logic [DW-1:0]    beats [BL];
    int               n_chk, n_fail;
    bit               done;

    rdcap_resync #(.LANES(LANES), .LANE_W(LANE_W), .CAS_W(CAS_W), .BURST_LEN(BL)) dut_i (
        .bus_clk    (bus_clk),
        .rst_n      (rst_n),
        .rd_clk     (rd_clk),
        .strobe_dly ({LANES{strobe}}),
        .lane_data  (lane_data),
        .rd_cmd     (rd_cmd),
        .stage_sel  (stage_sel),
        .cas_ofs    (cas_ofs),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    // 125 MHz bus clock rising at 4+8k; read clock at +1 ns, strobe at +5 ns
    initial begin bus_clk = 1'b0; forever #4 bus_clk = ~bus_clk; end
    initial begin rd_clk = 1'b0; #5; forever begin rd_clk = 1'b1; #4; rd_clk = 1'b0; #4; end end
    initial begin strobe = 1'b0; #9; forever begin strobe = 1'b1; #4; strobe = 1'b0; #4; end end

    function automatic logic [DW-1:0] rnd_word();
        logic [95:0] t;
        t = {$urandom(), $urandom(), $urandom()};
        return t[DW-1:0];
    endfunction

    function automatic int exp_lat(input logic [1:0] s, input logic [CAS_W-1:0] c);
        int e;
        e = (c == '0) ? 1 : int'(c);
        return e + ((s == 2'd3) ? 2 : int'(s));
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_burst(input logic [1:0] sel, input logic [CAS_W-1:0] cas,
                             input bit disturb, input bit extra);
        int    lat, pre;
        string lbl;
        lat = exp_lat(sel, cas);
        pre = ((cas == '0) ? 1 : int'(cas)) - 1;
        if (sel == 2'd3)       lbl = "R3 R5 valid";
        else if (cas == '0)    lbl = "R8 R5 valid";
        else if (extra)        lbl = "R7 R5 valid";
        else if (disturb)      lbl = "R6 R5 valid";
        else                   lbl = "R2 R5 valid";
        for (int b = 0; b < BL; b++) beats[b] = rnd_word();
        @(negedge bus_clk);
        stage_sel = sel;
        cas_ofs   = cas;
        rd_cmd    = 1'b1;
        @(posedge bus_clk);
        fork
            begin #1 rd_cmd = 1'b0; end
            begin
                repeat (pre) @(posedge bus_clk);
                for (int b = 0; b < BL; b++) begin
                    #2 lane_data = beats[b];
                    @(posedge bus_clk);
                end
                #2 lane_data = rnd_word();
            end
            begin
                if (disturb) begin
                    repeat (2) @(negedge bus_clk);
                    stage_sel = 2'($urandom());
                    cas_ofs   = CAS_W'($urandom());
                    if (extra) rd_cmd = 1'b1;
                    @(negedge bus_clk);
                    rd_cmd = 1'b0;
                end
            end
            begin
                for (int i = 0; i < lat + BL + 12; i++) begin
                    logic ev;
                    @(negedge bus_clk);
                    ev = (i >= lat) && (i < lat + BL);
                    chk(lbl, DW'(rd_valid), DW'(ev));
                    if (ev) chk((sel == 2'd2 || sel == 2'd3) ? "R4 R3 data" : "R4 data",
                                rd_data, beats[i - lat]);
                end
            end
        join
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        n_chk = 0; n_fail = 0; done = 1'b0;
        rst_n = 1'b0; rd_cmd = 1'b0; stage_sel = 2'd0; cas_ofs = CAS_W'(1);
        lane_data = '0;
        repeat (3) @(posedge bus_clk);
        @(negedge bus_clk);
        chk("R1 valid", DW'(rd_valid), '0);
        chk("R1 data", rd_data, '0);
        rst_n = 1'b1;
        @(negedge bus_clk);
        chk("R1 valid", DW'(rd_valid), '0);
        chk("R1 data", rd_data, '0);

        // Directed: each stage code at minimum offset, then the extremes
        for (int s = 0; s < 4; s++) run_burst(2'(s), CAS_W'(1), 1'b0, 1'b0);
        run_burst(2'd0, CAS_W'(0), 1'b0, 1'b0);
        run_burst(2'd3, CAS_W'(0), 1'b0, 1'b0);
        run_burst(2'd2, CAS_W'(7), 1'b0, 1'b0);
        run_burst(2'd0, CAS_W'(1), 1'b1, 1'b1);
        run_burst(2'd1, CAS_W'(3), 1'b1, 1'b0);

        // Random bursts with random gaps
        for (int n = 0; n < 40; n++) begin
            logic [1:0]       rs;
            logic [CAS_W-1:0] rc;
            bit               rd, rx;
            rs = 2'($urandom());
            rc = CAS_W'($urandom());
            rd = 1'($urandom());
            rx = rd & 1'($urandom());
            run_burst(rs, rc, rd, rx);
            repeat ($urandom() % 4) @(posedge bus_clk);
        end
        finish_run();
    end

endmodule